// File: doc/BRIEF.md
# Dual-Role SPI Controller with Port Remap

This block moves one byte at a time over a four-wire SPI link. A mode bit sets its role. As master it generates the serial clock itself. The clock comes either from a tap of a free-running prescaler on the system clock or from an external timer overflow pulse. As slave it follows the clock that the remote master drives in, and it takes part only while its active-low select line is low, or whenever select checking is switched off. The clock idles low. Data is sampled on the rising edge and changed on the falling edge, most significant bit first.

The four SPI signals share an 8-bit general-purpose port. A remap bit chooses one of two pin sets. A programming-path select input forces the alternate set whatever the remap bit holds. Port bits that the active pin set does not claim carry the general-purpose output value and enable unchanged. A master that sees its select line pulled low, with select checking on, records a mode fault and gives up the bus.

Top module: `spi_dualrole`

## Requirements
- R1: In master role the SCK and MOSI pins are driven (enable 1) and MISO is an input. A byte written on the transmit port is shifted out MSB first over exactly 8 SCK cycles. The byte sampled from MISO on the rising edges appears on `rx_data`.
- R2: In slave role SCK, MOSI and SS are inputs. MISO is driven only while the block is selected. MOSI is sampled on the rising edges of the incoming SCK, the next bit moves out on its falling edges, and the received byte appears on `rx_data` after the eighth falling edge.
- R3: In master role a rate code c from 0 to 6 gives SCK half-periods of 2^(c+1) system clocks. Code 7 advances SCK by one half-period per `tmr_ovf` pulse.
- R4: With select ignore set, the SS pin level has no effect: a master raises no fault, a slave counts as selected, and the SS pin position carries the general-purpose output and enable.
- R5: With master role, select ignore clear and the SS pin low, the fault flag sets, the master bit clears and the SCK and MOSI drivers are released.
- R6: The done flag sets after the eighth bit of a transfer. A status read clears both the done and fault flags.
- R7: With remap 0 the pins are SS=bit 1, MISO=bit 5, SCK=bit 6, MOSI=bit 7. With remap 1 they are SS=bit 4, MOSI=bit 5, MISO=bit 6, SCK=bit 7.
- R8: With `prog_sel` high the remap-1 pin set is used even when remap is 0.
- R9: Port bits not claimed by the active pin set carry `gpio_out` and `gpio_oe` unchanged.
- R10: After reset the role is slave, both flags are 0 and no SPI pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_master | input | 1 | Role: 1 master, 0 slave |
| cfg_rate | input | RATE_W | Master rate code, top code selects timer overflow |
| cfg_remap | input | 1 | Pin set select |
| cfg_ss_ignore | input | 1 | Ignore the SS pin |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| stat_master | output | 1 | Current role bit |
| stat_done | output | 1 | Transfer-complete flag |
| stat_fault | output | 1 | Mode-fault flag |
| tx_valid | input | 1 | Load transmit byte (starts a master transfer) |
| tx_data | input | DATA_W | Transmit byte |
| rx_data | output | DATA_W | Last received byte |
| tmr_ovf | input | 1 | Timer overflow pulse |
| prog_sel | input | 1 | Programming path active, forces the remap-1 pin set |
| gpio_out | input | 8 | General-purpose output values |
| gpio_oe | input | 8 | General-purpose output enables |
| pad_in | input | 8 | Port pin levels |
| pad_out | output | 8 | Port pin output values |
| pad_oe | output | 8 | Port pin output enables |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 7-bit prescaler, which gives eight rate codes. It uses prescaler codes 0, 1 and 2 and the timer code, so it can measure the SCK half-period from both clock sources. Both pin sets are used in master transfers, reached through the remap bit and through the programming-path select. Slave transfers are run with select driven and with select ignored, and the fault path is triggered from the SS pin.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned PIN_W  = $clog2(PORT_W);

  typedef struct packed {
    logic [PIN_W-1:0] ss;
    logic [PIN_W-1:0] miso;
    logic [PIN_W-1:0] mosi;
    logic [PIN_W-1:0] sck;
  } pinset_t;

  localparam pinset_t SET_BASE = '{ss: PIN_W'(1), miso: PIN_W'(5), mosi: PIN_W'(7), sck: PIN_W'(6)};
  localparam pinset_t SET_ALT  = '{ss: PIN_W'(4), miso: PIN_W'(6), mosi: PIN_W'(5), sck: PIN_W'(7)};
endpackage

// File: rtl/spi_dr_clkgen.sv
module spi_dr_clkgen #(
  parameter int PRE_W  = 7,
  parameter int RATE_W = $clog2(PRE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  input  logic              tmr_ovf,
  output logic              tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W:0]   taps;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < PRE_W; g++) begin : g_tap
    assign taps[g] = &cnt[g:0];
  end
  assign taps[PRE_W] = tmr_ovf;

  assign tick = run && taps[rate];
endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_master,
  input  logic              abort,
  input  logic              load_req,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              miso_in,
  input  logic              s_sck,
  input  logic              s_mosi,
  input  logic              s_sel,
  output logic              sck_q,
  output logic              ser_o,
  output logic              busy,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  bitcnt;
  logic              smp;
  logic              s_sck_d;
  logic              last_bit;
  logic              s_rise, s_fall;

  assign ser_o    = sr[DATA_W-1];
  assign last_bit = (bitcnt == CNT_W'(DATA_W - 1));
  assign s_rise   = s_sck & ~s_sck_d;
  assign s_fall   = ~s_sck & s_sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; bitcnt <= '0; smp <= 1'b0; s_sck_d <= 1'b0;
      sck_q <= 1'b0; busy <= 1'b0; done_pulse <= 1'b0; rx_byte <= '0;
    end else begin
      done_pulse <= 1'b0;
      s_sck_d    <= s_sck;
      if (abort) begin
        busy <= 1'b0; sck_q <= 1'b0; bitcnt <= '0;
      end else if (role_master) begin
        if (!busy) begin
          if (load_req) begin
            sr <= tx_byte; busy <= 1'b1; bitcnt <= '0; sck_q <= 1'b0;
          end
        end else if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            smp   <= miso_in;
          end else begin
            sck_q  <= 1'b0;
            sr     <= {sr[DATA_W-2:0], smp};
            bitcnt <= bitcnt + 1'b1;
            if (last_bit) begin
              busy <= 1'b0; done_pulse <= 1'b1; rx_byte <= {sr[DATA_W-2:0], smp};
            end
          end
        end
      end else begin
        sck_q <= 1'b0;
        if (!s_sel) begin
          bitcnt <= '0; busy <= 1'b0;
          if (load_req) sr <= tx_byte;
        end else begin
          if (load_req && !busy) sr <= tx_byte;
          if (s_rise) begin
            smp <= s_mosi; busy <= 1'b1;
          end
          if (s_fall) begin
            sr     <= {sr[DATA_W-2:0], smp};
            bitcnt <= bitcnt + 1'b1;
            if (last_bit) begin
              busy <= 1'b0; done_pulse <= 1'b1; rx_byte <= {sr[DATA_W-2:0], smp};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_dr_pinmux.sv
module spi_dr_pinmux
  import spi_dr_pkg::*;
(
  input  logic              use_alt,
  input  logic              drive_clk,
  input  logic              drive_miso,
  input  logic              claim_ss,
  input  logic              sck_o,
  input  logic              ser_o,
  input  logic [PORT_W-1:0] gpio_out,
  input  logic [PORT_W-1:0] gpio_oe,
  input  logic [PORT_W-1:0] pad_raw,
  input  logic [PORT_W-1:0] pad_sync,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              miso_raw,
  output logic              sck_s,
  output logic              mosi_s,
  output logic              ss_s
);
  pinset_t m;

  always_comb begin
    m        = use_alt ? SET_ALT : SET_BASE;
    miso_raw = pad_raw[m.miso];
    sck_s    = pad_sync[m.sck];
    mosi_s   = pad_sync[m.mosi];
    ss_s     = pad_sync[m.ss];
    for (int b = 0; b < PORT_W; b++) begin
      pin_out[b] = gpio_out[b];
      pin_oe[b]  = gpio_oe[b];
      if (PIN_W'(b) == m.sck) begin
        pin_out[b] = sck_o; pin_oe[b] = drive_clk;
      end else if (PIN_W'(b) == m.mosi) begin
        pin_out[b] = ser_o; pin_oe[b] = drive_clk;
      end else if (PIN_W'(b) == m.miso) begin
        pin_out[b] = ser_o; pin_oe[b] = drive_miso;
      end else if (claim_ss && PIN_W'(b) == m.ss) begin
        pin_out[b] = 1'b0; pin_oe[b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dualrole.sv
module spi_dualrole
  import spi_dr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRE_W   = 7,
  parameter int SYNC_N  = 2,
  localparam int RATE_W = $clog2(PRE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_master,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_remap,
  input  logic              cfg_ss_ignore,
  input  logic              stat_rd,
  output logic              stat_master,
  output logic              stat_done,
  output logic              stat_fault,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tmr_ovf,
  input  logic              prog_sel,
  input  logic [PORT_W-1:0] gpio_out,
  input  logic [PORT_W-1:0] gpio_oe,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  logic              master_q, remap_q, ssign_q, done_q, fault_q;
  logic [RATE_W-1:0] rate_q;
  logic [PORT_W-1:0] sync_q [SYNC_N];
  logic [PORT_W-1:0] pin_out, pin_oe;
  logic              use_alt, miso_raw, sck_s, mosi_s, ss_s, sel;
  logic              fault_evt, tick, sck_int, ser_o, busy, done_pulse;

  assign use_alt   = remap_q | prog_sel;
  assign sel       = ssign_q | ~ss_s;
  assign fault_evt = master_q & ~ssign_q & ~ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_N; s++) sync_q[s] <= '1;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_N; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  spi_dr_clkgen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_clk (
    .clk(clk), .rst(rst), .run(master_q & busy), .rate(rate_q),
    .tmr_ovf(tmr_ovf), .tick(tick)
  );

  spi_dr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .role_master(master_q), .abort(fault_evt),
    .load_req(tx_valid), .tx_byte(tx_data), .tick(tick), .miso_in(miso_raw),
    .s_sck(sck_s), .s_mosi(mosi_s), .s_sel(sel), .sck_q(sck_int), .ser_o(ser_o),
    .busy(busy), .done_pulse(done_pulse), .rx_byte(rx_data)
  );

  spi_dr_pinmux u_mux (
    .use_alt(use_alt), .drive_clk(master_q), .drive_miso(~master_q & sel),
    .claim_ss(~ssign_q), .sck_o(sck_int), .ser_o(ser_o), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .pad_raw(pad_in), .pad_sync(sync_q[SYNC_N-1]),
    .pin_out(pin_out), .pin_oe(pin_oe), .miso_raw(miso_raw), .sck_s(sck_s),
    .mosi_s(mosi_s), .ss_s(ss_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0; rate_q <= '0; remap_q <= 1'b0; ssign_q <= 1'b0;
      done_q <= 1'b0; fault_q <= 1'b0; pad_out <= '0; pad_oe <= '0;
    end else begin
      if (cfg_we) begin
        master_q <= cfg_master; rate_q <= cfg_rate;
        remap_q  <= cfg_remap;  ssign_q <= cfg_ss_ignore;
      end
      if (fault_evt) master_q <= 1'b0;
      done_q  <= done_pulse | (done_q & ~stat_rd);
      fault_q <= fault_evt | (fault_q & ~stat_rd);
      pad_out <= pin_out;
      pad_oe  <= pin_oe;
    end
  end

  assign stat_master = master_q;
  assign stat_done   = done_q;
  assign stat_fault  = fault_q;
endmodule

// File: rtl/spi_dr_chk.sv
module spi_dr_chk
  import spi_dr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              master_q,
  input logic              ssign_q,
  input logic              fault_q,
  input logic              done_q,
  input logic              stat_rd,
  input logic              done_pulse,
  input logic              use_alt,
  input logic [PORT_W-1:0] pad_oe,
  input logic              sck_int,
  input logic              tick,
  input logic              fault_evt
);
  // R5: the fault flag rises in the same cycle the role drops to slave
  assert_fault_drops_master_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> !master_q);

  // R6: a status read with no transfer ending clears the done flag
  assert_read_clears_done_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done_pulse) |=> !done_q);

  // R2: the base pin set never drives SCK or MOSI in slave role
  assert_slave_base_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(master_q) && !$past(use_alt)) |-> (!pad_oe[SET_BASE.sck] && !pad_oe[SET_BASE.mosi]));

  // R2: the alternate pin set never drives SCK or MOSI in slave role
  assert_slave_alt_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(master_q) && $past(use_alt)) |-> (!pad_oe[SET_ALT.sck] && !pad_oe[SET_ALT.mosi]));

  // R3: the master clock only moves on a rate tick
  assert_sck_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (master_q && !tick && !fault_evt) |=> $stable(sck_int));

  // R4: with select ignored no fault can be raised
  assert_ignore_blocks_fault_R4: assert property (@(posedge clk) disable iff (rst)
    ssign_q |=> !$rose(fault_q));
endmodule

bind spi_dualrole spi_dr_chk u_chk (
  .clk(clk), .rst(rst), .master_q(master_q), .ssign_q(ssign_q), .fault_q(fault_q),
  .done_q(done_q), .stat_rd(stat_rd), .done_pulse(done_pulse), .use_alt(use_alt),
  .pad_oe(pad_oe), .sck_int(sck_int), .tick(tick), .fault_evt(fault_evt)
);

// File: tb/spi_dualrole_tb.sv
module spi_dualrole_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, cfg_we, cfg_master, cfg_remap, cfg_ss_ignore, stat_rd;
  logic [2:0] cfg_rate;
  logic       stat_master, stat_done, stat_fault, tx_valid, tmr_ovf, prog_sel;
  logic [7:0] tx_data, rx_data, gpio_out, gpio_oe, pad_base, pad_in, pad_out, pad_oe;
  logic       slv_en, slv_miso;
  int p_ss = 1, p_miso = 5, p_mosi = 7, p_sck = 6;
  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  bit wd_fail = 1'b0, ended = 1'b0;
  logic [7:0] exp_q[$];

  always_comb begin
    pad_in = pad_base;
    if (slv_en) pad_in[p_miso] = slv_miso;
  end

  spi_dualrole u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_master(cfg_master), .cfg_rate(cfg_rate),
    .cfg_remap(cfg_remap), .cfg_ss_ignore(cfg_ss_ignore), .stat_rd(stat_rd),
    .stat_master(stat_master), .stat_done(stat_done), .stat_fault(stat_fault),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_data(rx_data), .tmr_ovf(tmr_ovf),
    .prog_sel(prog_sel), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // timer overflow source: one pulse every 5 clocks
  initial begin
    tmr_ovf = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      tmr_ovf = 1'b1;
      @(negedge clk);
      tmr_ovf = 1'b0;
    end
  end

  // scoreboard monitor: compares rx_data with the queued byte on every new done (R1, R2, R6)
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (stat_done && !done_prev) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R6 unexpected done actual=%0h expected=none", rx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          mon_fails++;
          $display("FAIL R1/R2 rx byte actual=%0h expected=%0h", rx_data, e);
        end
      end
    end
    done_prev <= stat_done;
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    int total, bad;
    if (!ended) begin
      ended = 1'b1;
      total = checks + mon_checks + (wd_fail ? 1 : 0);
      bad   = fails + mon_fails + (wd_fail ? 1 : 0);
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  task automatic use_set(input bit alt);
    if (alt) begin p_ss = 4; p_mosi = 5; p_miso = 6; p_sck = 7; end
    else     begin p_ss = 1; p_miso = 5; p_sck = 6; p_mosi = 7; end
  endtask

  task automatic cfg(input bit m, input int r, input bit rm, input bit ig);
    @(negedge clk);
    cfg_we = 1'b1; cfg_master = m; cfg_rate = 3'(r); cfg_remap = rm; cfg_ss_ignore = ig;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_status(input string tag);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(stat_done, 0, {tag, " R6 done cleared by read"});
  endtask

  task automatic master_xfer(input logic [7:0] txb, input logic [7:0] sv,
                             input string tag, output int hw);
    logic [7:0] cap, sr;
    logic prv;
    int n, rises;
    bit first;
    exp_q.push_back(sv);
    sr = sv; cap = '0; slv_miso = sv[7]; slv_en = 1'b1; hw = 0; first = 1'b1; rises = 0;
    @(negedge clk); tx_valid = 1'b1; tx_data = txb;
    @(negedge clk); tx_valid = 1'b0;
    prv = pad_out[p_sck]; n = 0;
    while (!stat_done && n < 5000) begin
      @(negedge clk); n++;
      if (pad_out[p_sck] && !prv) begin cap = {cap[6:0], pad_out[p_mosi]}; rises++; end
      if (!pad_out[p_sck] && prv) begin sr = {sr[6:0], 1'b0}; slv_miso = sr[7]; first = 1'b0; end
      if (pad_out[p_sck] && first) hw++;
      prv = pad_out[p_sck];
    end
    chk(int'(cap), int'(txb), {tag, " R1 MOSI byte"});
    chk(rises, 8, {tag, " R1 SCK cycle count"});
    clear_status(tag);
    slv_en = 1'b0;
  endtask

  task automatic slave_xfer(input logic [7:0] dtx, input logic [7:0] mtx,
                            input bit drive_ss, input string tag);
    logic [7:0] got;
    int n;
    got = '0;
    exp_q.push_back(mtx);
    pad_base[p_sck] = 1'b0;
    repeat (4) @(negedge clk);
    chk(pad_oe[p_miso], drive_ss ? 0 : 1, {tag, " R2 MISO enable before select"});
    tx_valid = 1'b1; tx_data = dtx;
    @(negedge clk); tx_valid = 1'b0;
    if (drive_ss) pad_base[p_ss] = 1'b0;
    repeat (H) @(negedge clk);
    chk(pad_oe[p_miso], 1, {tag, " R2 MISO driven when selected"});
    for (int i = 7; i >= 0; i--) begin
      pad_base[p_mosi] = mtx[i];
      repeat (H) @(negedge clk);
      pad_base[p_sck] = 1'b1;
      got = {got[6:0], pad_out[p_miso]};
      repeat (H) @(negedge clk);
      pad_base[p_sck] = 1'b0;
    end
    n = 0;
    while (!stat_done && n < 100) begin @(negedge clk); n++; end
    chk(int'(got), int'(dtx), {tag, " R2 MISO byte"});
    pad_base[p_ss] = 1'b1;
    repeat (4) @(negedge clk);
    chk(pad_oe[p_miso], drive_ss ? 0 : 1, {tag, " R2 MISO enable after select"});
    clear_status(tag);
  endtask

  initial begin
    int hw;
    rst = 1'b1; cfg_we = 1'b0; cfg_master = 1'b0; cfg_rate = '0; cfg_remap = 1'b0;
    cfg_ss_ignore = 1'b0; stat_rd = 1'b0; tx_valid = 1'b0; tx_data = '0; prog_sel = 1'b0;
    gpio_out = 8'h3C; gpio_oe = 8'hFF; pad_base = 8'hFF; slv_en = 1'b0; slv_miso = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // reset state
    chk(stat_master, 0, "R10 role after reset");
    chk(stat_done, 0, "R10 done after reset");
    chk(stat_fault, 0, "R10 fault after reset");
    chk(int'(pad_oe & 8'hE2), 0, "R10 SPI pins undriven after reset");
    chk(int'(pad_oe & 8'h1D), 8'h1D, "R9 free pin enables");
    chk(int'(pad_out & 8'h1D), int'(gpio_out & 8'h1D), "R9 free pin values");

    // master, base pins, various rates
    use_set(1'b0);
    cfg(1'b1, 1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk(int'(pad_oe & 8'hE0), 8'hC0, "R1 SCK/MOSI driven, MISO input");
    master_xfer(8'hA5, 8'h3C, "m rate1", hw);
    chk(hw, 4, "R3 rate 1 half-period");
    cfg(1'b1, 2, 1'b0, 1'b0);
    master_xfer(8'h81, 8'h7E, "m rate2", hw);
    chk(hw, 8, "R3 rate 2 half-period");
    cfg(1'b1, 7, 1'b0, 1'b0);
    master_xfer(8'h5A, 8'hC3, "m timer", hw);
    chk(hw, 5, "R3 timer overflow half-period");

    // remapped pins
    use_set(1'b1);
    cfg(1'b1, 0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(int'(pad_oe & 8'hE0), 8'hA0, "R7 remap SCK bit7 MOSI bit5 MISO bit6");
    chk(int'(pad_out & 8'h0F), int'(gpio_out & 8'h0F), "R9 free pins under remap");
    chk(pad_oe[1], 1, "R7 bit1 released under remap");
    master_xfer(8'h0F, 8'hF0, "m remap", hw);
    chk(hw, 2, "R3 rate 0 half-period");

    // programming path forces the remap-1 set
    cfg(1'b1, 1, 1'b0, 1'b0);
    prog_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk(int'(pad_oe & 8'hE0), 8'hA0, "R8 programming path pin set");
    master_xfer(8'h96, 8'h69, "m prog", hw);
    prog_sel = 1'b0;

    // mode fault
    use_set(1'b0);
    cfg(1'b1, 1, 1'b0, 1'b0);
    pad_base[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk(stat_fault, 1, "R5 fault flag set");
    chk(stat_master, 0, "R5 role dropped");
    chk(int'(pad_oe & 8'hC0), 0, "R5 SCK/MOSI released");
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(stat_fault, 0, "R6 fault cleared by read");
    pad_base[1] = 1'b1;

    // select ignored in master role
    cfg(1'b1, 1, 1'b0, 1'b1);
    pad_base[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk(stat_fault, 0, "R4 no fault when ignored");
    chk(stat_master, 1, "R4 role kept");
    chk(int'({pad_oe[1], pad_out[1]}), int'({gpio_oe[1], gpio_out[1]}), "R4 SS bit to GPIO");
    master_xfer(8'hE7, 8'h18, "m ignore", hw);
    pad_base[1] = 1'b1;

    // slave role
    cfg(1'b0, 0, 1'b0, 1'b0);
    slave_xfer(8'hC3, 8'h5A, 1'b1, "s select");
    cfg(1'b0, 0, 1'b0, 1'b1);
    slave_xfer(8'h2D, 8'hB4, 1'b0, "s ignore");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R6 every transfer reported done");
    report();
  end
endmodule